// File: doc/BRIEF.md
# CAN Frame Field Parser

This block sits behind a CAN bit sampler and destuffer. Each cycle in which `bit_vld` is high, it takes one destuffed bit with its position in the frame, counted from the start-of-frame bit at 0. The position alone decides what the bit means. The identifier-extension bit at position 13 chooses between the standard and extended layouts. The received length code then fixes where the data field ends and where the checksum and the frame tail lie.

Every field goes out through registered outputs with its own one-cycle strobe. These fields are:
- the base identifier
- the extended and combined 29-bit identifiers
- the control bits together with the length code
- each payload byte
- the received checksum
- the acknowledge slot

A recessive start bit, a checksum mismatch and a dominant bit where the format requires recessive each raise a one-cycle warning. `frame_end` pulses on the last end-of-frame bit so that the sampler can return to idle. A checksum is computed in line over the bits from position 0 through the last data bit and compared with the received sequence.

Top module: `can_field_parser`

## Requirements
- R1: Position 0 is the start bit; if it is recessive (1), `warn_sof` pulses in the cycle after that bit is accepted, otherwise it stays low.
- R2: Positions 1..11 form `base_id` MSB first; `id_vld` pulses once per frame, in the cycle after position 11 is accepted.
- R3: Position 13 selects the layout (0 = standard, 1 = extended); `ctl_vld` pulses after the last length-code bit (position 18 standard, 38 extended) with `ide`, `remote`, `srr`, `rb0`, `rb1` and the 4-bit `dlc` taken from the four bits ending there, MSB first.
- R4: In a standard frame `remote` equals the bit at position 12 (1 = remote frame), `rb0` is the bit at position 14, and `srr`, `rb1` read 0; `ext_vld` never pulses.
- R5: In an extended frame positions 14..31 form `ext_id` MSB first, `ext_vld` pulses after position 31 with `full_id` = `base_id`<<18 | `ext_id`; `srr` is position 12, `remote` position 32, `rb1` position 33, `rb0` position 34.
- R6: Recessive reserved bits are accepted: they raise no warning and the rest of the frame parses normally.
- R7: Payload bytes follow the length code, MSB first; after the eighth bit of byte k, `byte_vld` pulses with `byte_idx` = k and the byte value. The number of bytes is min(dlc, 8), and zero for a remote frame whatever the length code says.
- R8: With L the last data bit (the length-code end for zero bytes), positions L+1..L+15 form `crc_rx`, strobed by `crc_vld` after L+15. `warn_crc` pulses in the same cycle when `crc_rx` differs from the CRC-15 (polynomial 0x4599, initial value 0, MSB shifted first) of the bits at positions 0..L.
- R9: `ack_vld` pulses after position L+17, with `ack` = 1 when that slot was dominant (0).
- R10: A dominant bit at L+16, at L+18 or at any of L+19..L+25 makes `warn_form` pulse in the cycle after that bit.
- R11: `frame_end` pulses exactly once per frame, in the cycle after position L+25.
- R12: Every strobe and warning comes one cycle after an accepted bit. Cycles with `bit_vld` low change nothing, whatever `bit_val` and `bit_idx` carry, and at most one field strobe is high in any cycle.
- R13: While `rst` is high and in the cycle after, all strobes and warnings are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | A destuffed bit is presented this cycle |
| bit_val | input | 1 | Bit value, 0 = dominant |
| bit_idx | input | 7 | Position of the bit in the frame, 0 = start bit |
| id_vld | output | 1 | Base identifier strobe |
| base_id | output | 11 | Base identifier |
| ext_vld | output | 1 | Extended identifier strobe |
| ext_id | output | 18 | Extended identifier |
| full_id | output | 29 | Combined identifier |
| ctl_vld | output | 1 | Control field strobe |
| ide | output | 1 | 1 = extended layout |
| remote | output | 1 | 1 = remote frame |
| srr | output | 1 | Substitute bit (extended only) |
| rb0 | output | 1 | Reserved bit 0 |
| rb1 | output | 1 | Reserved bit 1 (extended only) |
| dlc | output | 4 | Received length code |
| byte_vld | output | 1 | Payload byte strobe |
| byte_idx | output | 3 | Payload byte number |
| byte_val | output | 8 | Payload byte value |
| crc_vld | output | 1 | Checksum field strobe |
| crc_rx | output | 15 | Received checksum |
| ack_vld | output | 1 | Acknowledge slot strobe |
| ack | output | 1 | 1 = slot was dominant |
| frame_end | output | 1 | Last end-of-frame bit seen |
| warn_sof | output | 1 | Recessive start bit |
| warn_crc | output | 1 | Checksum mismatch |
| warn_form | output | 1 | Dominant delimiter or end-of-frame bit |

## Verification
The bench builds the parser with its default parameters: a 7-bit position, eight payload bytes at most and a 15-bit checksum. These values reach every position up to 127, which is the tail of an extended frame carrying eight bytes. They also cover a length code of 15, which must clamp to eight bytes, and each of the eight byte numbers. Random idle gaps carrying garbage on `bit_val` and `bit_idx` sit between bits, together with directed frames for each warning and for remote frames. Every layout branch and every tail offset is therefore exercised at its largest value.

// File: rtl/can_parse_pkg.sv
package can_parse_pkg;

  // Fixed frame positions (destuffed bit numbers)
  localparam int POS_SOF      = 0;
  localparam int POS_ID_LAST  = 11;
  localparam int POS_B12      = 12;
  localparam int POS_IDE      = 13;
  localparam int POS_STD_RB0  = 14;
  localparam int POS_STD_DLC  = 18;
  localparam int POS_EXT_LAST = 31;
  localparam int POS_EXT_RTR  = 32;
  localparam int POS_EXT_RB1  = 33;
  localparam int POS_EXT_RB0  = 34;
  localparam int POS_EXT_DLC  = 38;

  // Offsets from the last data bit
  localparam int OFS_CRC_LAST = 15;
  localparam int OFS_CRC_DEL  = 16;
  localparam int OFS_ACK      = 17;
  localparam int OFS_ACK_DEL  = 18;
  localparam int OFS_EOF_FST  = 19;
  localparam int OFS_EOF_LST  = 25;

  typedef enum logic [3:0] {
    ROLE_NONE,
    ROLE_SOF,
    ROLE_ID_LAST,
    ROLE_B12,
    ROLE_IDE,
    ROLE_EXT_LAST,
    ROLE_RTRX,
    ROLE_RB1,
    ROLE_RB0,
    ROLE_DLC_LAST,
    ROLE_DATA,
    ROLE_CRC_LAST,
    ROLE_RECESSIVE,
    ROLE_ACK,
    ROLE_EOF_LAST
  } role_e;

endpackage

// File: rtl/can_bit_role.sv
module can_bit_role
  import can_parse_pkg::*;
#(
  parameter int IDX_W     = 7,
  parameter int BYTE_IX_W = 3
) (
  input  logic [IDX_W-1:0]     idx,
  input  logic                 ide_q,
  input  logic [IDX_W-1:0]     last_q,
  output role_e                role,
  output logic                 in_cov,
  output logic                 byte_end,
  output logic [BYTE_IX_W-1:0] byte_ix,
  output logic [IDX_W-1:0]     dlc_end
);

  logic [IDX_W-1:0] off;
  logic [IDX_W-1:0] tail;

  always_comb begin
    dlc_end  = ide_q ? IDX_W'(POS_EXT_DLC) : IDX_W'(POS_STD_DLC);
    off      = idx - dlc_end - 1'b1;
    tail     = idx - last_q;
    role     = ROLE_NONE;
    in_cov   = 1'b0;
    byte_end = 1'b0;
    byte_ix  = BYTE_IX_W'(off >> 3);

    if (idx <= IDX_W'(POS_IDE)) begin
      in_cov = 1'b1;
      if (idx == IDX_W'(POS_SOF))          role = ROLE_SOF;
      else if (idx == IDX_W'(POS_ID_LAST)) role = ROLE_ID_LAST;
      else if (idx == IDX_W'(POS_B12))     role = ROLE_B12;
      else if (idx == IDX_W'(POS_IDE))     role = ROLE_IDE;
    end else if (idx <= dlc_end) begin
      in_cov = 1'b1;
      if (idx == dlc_end)                                 role = ROLE_DLC_LAST;
      else if (ide_q && idx == IDX_W'(POS_EXT_LAST))      role = ROLE_EXT_LAST;
      else if (ide_q && idx == IDX_W'(POS_EXT_RTR))       role = ROLE_RTRX;
      else if (ide_q && idx == IDX_W'(POS_EXT_RB1))       role = ROLE_RB1;
      else if (ide_q && idx == IDX_W'(POS_EXT_RB0))       role = ROLE_RB0;
      else if (!ide_q && idx == IDX_W'(POS_STD_RB0))      role = ROLE_RB0;
    end else if (idx <= last_q) begin
      in_cov   = 1'b1;
      role     = ROLE_DATA;
      byte_end = (off[2:0] == 3'b111);
    end else begin
      if (tail == IDX_W'(OFS_CRC_LAST))       role = ROLE_CRC_LAST;
      else if (tail == IDX_W'(OFS_ACK))       role = ROLE_ACK;
      else if (tail == IDX_W'(OFS_EOF_LST))   role = ROLE_EOF_LAST;
      else if (tail == IDX_W'(OFS_CRC_DEL) || tail == IDX_W'(OFS_ACK_DEL) ||
               (tail >= IDX_W'(OFS_EOF_FST) && tail < IDX_W'(OFS_EOF_LST)))
        role = ROLE_RECESSIVE;
    end
  end

endmodule

// File: rtl/can_crc_unit.sv
module can_crc_unit #(
  parameter int               CRC_W = 15,
  parameter logic [CRC_W-1:0] POLY  = 15'h4599
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);

  logic [CRC_W-1:0] base;
  logic [CRC_W-1:0] nxt;

  always_comb begin
    base = restart ? '0 : crc;
    nxt  = {base[CRC_W-2:0], 1'b0};
    if (din ^ base[CRC_W-1]) nxt = nxt ^ POLY;
  end

  always_ff @(posedge clk) begin
    if (rst)     crc <= '0;
    else if (en) crc <= nxt;
  end

  // R8: the register restarts from zero at the start bit
  p_crc_seed_r8: assert property (@(posedge clk) disable iff (rst)
    (en && restart) |=> (crc == ($past(din) ? POLY : '0)));

endmodule

// File: rtl/can_field_shift.sv
module can_field_shift #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] sh
);

  always_ff @(posedge clk) begin
    if (rst)     sh <= '0;
    else if (en) sh <= {sh[W-2:0], din};
  end

endmodule

// File: rtl/can_field_parser.sv
module can_field_parser
  import can_parse_pkg::*;
#(
  parameter int               IDX_W     = 7,
  parameter int               BASE_W    = 11,
  parameter int               EXT_W     = 18,
  parameter int               DLC_W     = 4,
  parameter int               MAX_BYTES = 8,
  parameter int               CRC_W     = 15,
  parameter logic [CRC_W-1:0] CRC_POLY  = 15'h4599
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bit_vld,
  input  logic                    bit_val,
  input  logic [IDX_W-1:0]        bit_idx,
  output logic                    id_vld,
  output logic [BASE_W-1:0]       base_id,
  output logic                    ext_vld,
  output logic [EXT_W-1:0]        ext_id,
  output logic [BASE_W+EXT_W-1:0] full_id,
  output logic                    ctl_vld,
  output logic                    ide,
  output logic                    remote,
  output logic                    srr,
  output logic                    rb0,
  output logic                    rb1,
  output logic [DLC_W-1:0]        dlc,
  output logic                    byte_vld,
  output logic [$clog2(MAX_BYTES)-1:0] byte_idx,
  output logic [7:0]              byte_val,
  output logic                    crc_vld,
  output logic [CRC_W-1:0]        crc_rx,
  output logic                    ack_vld,
  output logic                    ack,
  output logic                    frame_end,
  output logic                    warn_sof,
  output logic                    warn_crc,
  output logic                    warn_form
);

  localparam int BYTE_IX_W = $clog2(MAX_BYTES);
  localparam int SH_W      = EXT_W - 1;

  role_e                role;
  logic                 in_cov;
  logic                 byte_end;
  logic [BYTE_IX_W-1:0] byte_ix;
  logic [IDX_W-1:0]     dlc_end;
  logic [SH_W-1:0]      sh;
  logic [CRC_W-1:0]     crc_calc;

  logic             ide_q, b12_q, rtrx_q, rb0_q, rb1_q;
  logic [IDX_W-1:0] last_q;

  logic [DLC_W-1:0] dlc_n;
  logic             rem_n;
  logic [DLC_W-1:0] nb_n;
  logic [CRC_W-1:0] crc_n;

  can_bit_role #(.IDX_W(IDX_W), .BYTE_IX_W(BYTE_IX_W)) u_role (
    .idx(bit_idx), .ide_q(ide_q), .last_q(last_q), .role(role),
    .in_cov(in_cov), .byte_end(byte_end), .byte_ix(byte_ix), .dlc_end(dlc_end)
  );

  can_field_shift #(.W(SH_W)) u_shift (
    .clk(clk), .rst(rst), .en(bit_vld), .din(bit_val), .sh(sh)
  );

  can_crc_unit #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst(rst), .en(bit_vld && in_cov),
    .restart(role == ROLE_SOF), .din(bit_val), .crc(crc_calc)
  );

  always_comb begin
    dlc_n = {sh[DLC_W-2:0], bit_val};
    rem_n = ide_q ? rtrx_q : b12_q;
    if (rem_n)                              nb_n = '0;
    else if (dlc_n > DLC_W'(MAX_BYTES))     nb_n = DLC_W'(MAX_BYTES);
    else                                    nb_n = dlc_n;
    crc_n = {sh[CRC_W-2:0], bit_val};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      id_vld <= 1'b0; ext_vld <= 1'b0; ctl_vld <= 1'b0; byte_vld <= 1'b0;
      crc_vld <= 1'b0; ack_vld <= 1'b0; frame_end <= 1'b0;
      warn_sof <= 1'b0; warn_crc <= 1'b0; warn_form <= 1'b0;
      base_id <= '0; ext_id <= '0; full_id <= '0;
      ide <= 1'b0; remote <= 1'b0; srr <= 1'b0; rb0 <= 1'b0; rb1 <= 1'b0;
      dlc <= '0; byte_idx <= '0; byte_val <= '0; crc_rx <= '0; ack <= 1'b0;
      ide_q <= 1'b0; b12_q <= 1'b0; rtrx_q <= 1'b0; rb0_q <= 1'b0; rb1_q <= 1'b0;
      last_q <= '0;
    end else begin
      id_vld <= 1'b0; ext_vld <= 1'b0; ctl_vld <= 1'b0; byte_vld <= 1'b0;
      crc_vld <= 1'b0; ack_vld <= 1'b0; frame_end <= 1'b0;
      warn_sof <= 1'b0; warn_crc <= 1'b0; warn_form <= 1'b0;
      if (bit_vld) begin
        case (role)
          ROLE_SOF:      warn_sof <= bit_val;
          ROLE_ID_LAST: begin
            base_id <= {sh[BASE_W-2:0], bit_val};
            id_vld  <= 1'b1;
          end
          ROLE_B12:      b12_q <= bit_val;
          ROLE_IDE:      ide_q <= bit_val;
          ROLE_EXT_LAST: begin
            ext_id  <= {sh[EXT_W-2:0], bit_val};
            full_id <= {base_id, sh[EXT_W-2:0], bit_val};
            ext_vld <= 1'b1;
          end
          ROLE_RTRX:     rtrx_q <= bit_val;
          ROLE_RB1:      rb1_q  <= bit_val;
          ROLE_RB0:      rb0_q  <= bit_val;
          ROLE_DLC_LAST: begin
            ctl_vld <= 1'b1;
            ide     <= ide_q;
            remote  <= rem_n;
            srr     <= ide_q & b12_q;
            rb0     <= rb0_q;
            rb1     <= ide_q & rb1_q;
            dlc     <= dlc_n;
            last_q  <= dlc_end + (IDX_W'(nb_n) << 3);
          end
          ROLE_DATA: begin
            if (byte_end) begin
              byte_vld <= 1'b1;
              byte_idx <= byte_ix;
              byte_val <= {sh[6:0], bit_val};
            end
          end
          ROLE_CRC_LAST: begin
            crc_vld  <= 1'b1;
            crc_rx   <= crc_n;
            warn_crc <= (crc_n != crc_calc);
          end
          ROLE_RECESSIVE: warn_form <= ~bit_val;
          ROLE_ACK: begin
            ack_vld <= 1'b1;
            ack     <= ~bit_val;
          end
          ROLE_EOF_LAST: begin
            warn_form <= ~bit_val;
            frame_end <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R12: no strobe without an accepted bit one cycle earlier
  p_strobe_cause_r12: assert property (@(posedge clk) disable iff (rst)
    (id_vld || ext_vld || ctl_vld || byte_vld || crc_vld || ack_vld ||
     frame_end || warn_sof || warn_crc || warn_form) |-> $past(bit_vld));

  // R12: at most one field strobe per cycle
  p_single_field_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({id_vld, ext_vld, ctl_vld, byte_vld, crc_vld, ack_vld, frame_end}));

  // R7: a remote frame is followed directly by the checksum, never a byte
  p_remote_nodata_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl_vld && remote) |=> !byte_vld);

  // R8: checksum warning only together with the checksum field
  p_crc_warn_field_r8: assert property (@(posedge clk) disable iff (rst)
    warn_crc |-> crc_vld);

  // R5: upper part of the combined identifier matches the held base identifier
  p_full_id_r5: assert property (@(posedge clk) disable iff (rst)
    ext_vld |-> (full_id[BASE_W+EXT_W-1:EXT_W] == base_id));

endmodule

// File: tb/tb_can_field_parser.sv
`timescale 1ns/1ps
module tb_can_field_parser;

  logic clk = 1'b0;
  logic rst;
  logic bit_vld, bit_val;
  logic [6:0] bit_idx;
  logic id_vld, ext_vld, ctl_vld, byte_vld, crc_vld, ack_vld, frame_end;
  logic [10:0] base_id;
  logic [17:0] ext_id;
  logic [28:0] full_id;
  logic ide, remote, srr, rb0, rb1, ack;
  logic [3:0] dlc;
  logic [2:0] byte_idx;
  logic [7:0] byte_val;
  logic [14:0] crc_rx;
  logic warn_sof, warn_crc, warn_form;

  always #10 clk = ~clk;

  can_field_parser dut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_val(bit_val), .bit_idx(bit_idx),
    .id_vld(id_vld), .base_id(base_id), .ext_vld(ext_vld), .ext_id(ext_id),
    .full_id(full_id), .ctl_vld(ctl_vld), .ide(ide), .remote(remote), .srr(srr),
    .rb0(rb0), .rb1(rb1), .dlc(dlc), .byte_vld(byte_vld), .byte_idx(byte_idx),
    .byte_val(byte_val), .crc_vld(crc_vld), .crc_rx(crc_rx), .ack_vld(ack_vld),
    .ack(ack), .frame_end(frame_end), .warn_sof(warn_sof), .warn_crc(warn_crc),
    .warn_form(warn_form)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // frame description
  logic f_ide, f_b12, f_rtrx, f_rb0, f_rb1, f_nack, f_sofbad;
  logic [10:0] f_bid;
  logic [17:0] f_eid;
  logic [3:0]  f_dlc;
  logic [7:0]  f_data [8];
  logic [14:0] f_crcx;
  int          f_bad;

  logic fr [128];
  int   n_bits;

  // observations
  int n_id, n_ext, n_ctl, n_byte, n_crc, n_ack, n_end, n_wsof, n_wcrc, n_wform, n_stray, n_order;
  logic [10:0] g_id; logic [17:0] g_eid; logic [28:0] g_fid;
  logic g_ide, g_rem, g_srr, g_rb0, g_rb1, g_ack;
  logic [3:0] g_dlc; logic [14:0] g_crc;
  logic [7:0] g_bytes [8];

  function automatic logic [14:0] crc15_ref(input int last);
    logic [14:0] c = '0;
    for (int i = 0; i <= last; i++) begin
      logic fb = fr[i] ^ c[14];
      c = {c[13:0], 1'b0};
      if (fb) c = c ^ 15'h4599;
    end
    return c;
  endfunction

  task automatic push(input logic v);
    fr[n_bits] = v;
    n_bits++;
  endtask

  function automatic int exp_bytes();
    logic rem = f_ide ? f_rtrx : f_b12;
    if (rem) return 0;
    return (f_dlc > 8) ? 8 : int'(f_dlc);
  endfunction

  task automatic build(output logic [14:0] crc_e);
    int nb = exp_bytes();
    n_bits = 0;
    push(f_sofbad);
    for (int i = 10; i >= 0; i--) push(f_bid[i]);
    push(f_b12);
    push(f_ide);
    if (!f_ide) push(f_rb0);
    else begin
      for (int i = 17; i >= 0; i--) push(f_eid[i]);
      push(f_rtrx); push(f_rb1); push(f_rb0);
    end
    for (int i = 3; i >= 0; i--) push(f_dlc[i]);
    for (int b = 0; b < nb; b++)
      for (int i = 7; i >= 0; i--) push(f_data[b][i]);
    crc_e = crc15_ref(n_bits - 1);
    for (int i = 14; i >= 0; i--) push(crc_e[i] ^ f_crcx[i]);
    push(f_bad == 1 ? 1'b0 : 1'b1);
    push(f_nack);
    push(f_bad == 2 ? 1'b0 : 1'b1);
    for (int k = 0; k < 7; k++) push((f_bad == 3 && k == 2) ? 1'b0 : 1'b1);
  endtask

  function automatic logic any_strobe();
    return id_vld | ext_vld | ctl_vld | byte_vld | crc_vld | ack_vld | frame_end |
           warn_sof | warn_crc | warn_form;
  endfunction

  task automatic observe();
    if (id_vld)  begin n_id++;  g_id = base_id; end
    if (ext_vld) begin n_ext++; g_eid = ext_id; g_fid = full_id; end
    if (ctl_vld) begin
      n_ctl++; g_ide = ide; g_rem = remote; g_srr = srr; g_rb0 = rb0; g_rb1 = rb1; g_dlc = dlc;
    end
    if (byte_vld) begin
      if (int'(byte_idx) != n_byte) n_order++;
      g_bytes[byte_idx] = byte_val;
      n_byte++;
    end
    if (crc_vld) begin n_crc++; g_crc = crc_rx; end
    if (ack_vld) begin n_ack++; g_ack = ack; end
    if (frame_end) n_end++;
    if (warn_sof)  n_wsof++;
    if (warn_crc)  n_wcrc++;
    if (warn_form) n_wform++;
  endtask

  task automatic run_frame(input int gapmax);
    logic [14:0] crc_e;
    int nb;
    build(crc_e);
    nb = exp_bytes();
    n_id = 0; n_ext = 0; n_ctl = 0; n_byte = 0; n_crc = 0; n_ack = 0; n_end = 0;
    n_wsof = 0; n_wcrc = 0; n_wform = 0; n_stray = 0; n_order = 0;
    for (int i = 0; i < n_bits; i++) begin
      bit_vld = 1'b1; bit_val = fr[i]; bit_idx = 7'(i);
      @(negedge clk);
      observe();
      bit_vld = 1'b0;
      for (int g = 0; g < int'($urandom_range(gapmax, 0)); g++) begin
        bit_val = 1'($urandom); bit_idx = 7'($urandom);
        @(negedge clk);
        if (any_strobe()) n_stray++;
      end
    end
    chk("R1 sof warning", 64'(n_wsof), 64'(f_sofbad));
    chk("R2 id count", 64'(n_id), 64'd1);
    chk("R2 base id", 64'(g_id), 64'(f_bid));
    chk("R3 ctl count", 64'(n_ctl), 64'd1);
    chk("R3 ide", 64'(g_ide), 64'(f_ide));
    chk("R3 dlc", 64'(g_dlc), 64'(f_dlc));
    if (!f_ide) begin
      chk("R4 std ext count", 64'(n_ext), 64'd0);
      chk("R4 std ctl bits", 64'({g_rem, g_srr, g_rb0, g_rb1}), 64'({f_b12, 1'b0, f_rb0, 1'b0}));
    end else begin
      chk("R5 ext count", 64'(n_ext), 64'd1);
      chk("R5 ext id", 64'(g_eid), 64'(f_eid));
      chk("R5 full id", 64'(g_fid), 64'({f_bid, f_eid}));
      chk("R5 ext ctl bits", 64'({g_rem, g_srr, g_rb0, g_rb1}), 64'({f_rtrx, f_b12, f_rb0, f_rb1}));
    end
    chk("R7 byte count", 64'(n_byte), 64'(nb));
    chk("R7 byte order", 64'(n_order), 64'd0);
    for (int b = 0; b < nb; b++) chk("R7 byte value", 64'(g_bytes[b]), 64'(f_data[b]));
    chk("R8 crc count", 64'(n_crc), 64'd1);
    chk("R8 crc field", 64'(g_crc), 64'(crc_e ^ f_crcx));
    chk("R8 crc warning", 64'(n_wcrc), 64'(f_crcx != 0));
    chk("R9 ack count", 64'(n_ack), 64'd1);
    chk("R9 ack value", 64'(g_ack), 64'(!f_nack));
    chk("R10 R6 form warnings", 64'(n_wform), 64'(f_bad != 0));
    chk("R11 frame end", 64'(n_end), 64'd1);
    chk("R12 idle strobes", 64'(n_stray), 64'd0);
  endtask

  task automatic clear_fields();
    f_ide = 0; f_b12 = 0; f_rtrx = 0; f_rb0 = 0; f_rb1 = 0; f_nack = 0; f_sofbad = 0;
    f_bid = '0; f_eid = '0; f_dlc = '0; f_crcx = '0; f_bad = 0;
    for (int i = 0; i < 8; i++) f_data[i] = 8'(8'h11 * (i + 1));
  endtask

  initial begin
    void'($urandom(32'd20240517));
    bit_vld = 0; bit_val = 0; bit_idx = '0;
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R13 strobes in reset", 64'(any_strobe()), 64'd0);
    rst = 0;
    @(negedge clk);
    chk("R13 strobes after reset", 64'(any_strobe()), 64'd0);

    // standard data frame, two bytes
    clear_fields(); f_bid = 11'h123; f_dlc = 4'd2; f_data[0] = 8'hA5; f_data[1] = 8'h3C;
    run_frame(0);
    // extended data frame, eight bytes, recessive reserved bits (R6)
    clear_fields(); f_ide = 1; f_b12 = 1; f_bid = 11'h7F0; f_eid = 18'h2AB5C;
    f_rb0 = 1; f_rb1 = 1; f_dlc = 4'd8; run_frame(2);
    // standard remote frame with nonzero length code (R7)
    clear_fields(); f_b12 = 1; f_bid = 11'h055; f_dlc = 4'd4; f_rb0 = 1; run_frame(1);
    // length code above eight clamps (R7)
    clear_fields(); f_bid = 11'h400; f_dlc = 4'd15; run_frame(0);
    // recessive start bit (R1)
    clear_fields(); f_sofbad = 1; f_bid = 11'h001; f_dlc = 4'd1; run_frame(0);
    // corrupted checksum (R8)
    clear_fields(); f_bid = 11'h2F2; f_dlc = 4'd3; f_crcx = 15'h0040; run_frame(1);
    // no acknowledge (R9)
    clear_fields(); f_ide = 1; f_eid = 18'h3FFFF; f_dlc = 4'd1; f_nack = 1; run_frame(0);
    // dominant delimiters and end-of-frame bit (R10)
    for (int k = 1; k <= 3; k++) begin
      clear_fields(); f_bid = 11'(k * 100); f_dlc = 4'(k); f_bad = k; run_frame(1);
    end
    // extended remote frame (R5, R7)
    clear_fields(); f_ide = 1; f_rtrx = 1; f_bid = 11'h6A1; f_eid = 18'h00F0F; f_dlc = 4'd3;
    run_frame(0);

    // constrained random frames
    for (int n = 0; n < 40; n++) begin
      clear_fields();
      f_ide = 1'($urandom); f_b12 = 1'($urandom); f_rtrx = ($urandom_range(3, 0) == 0);
      if (!f_ide) f_b12 = ($urandom_range(3, 0) == 0);
      f_rb0 = 1'($urandom); f_rb1 = 1'($urandom); f_nack = ($urandom_range(7, 0) == 0);
      f_bid = 11'($urandom); f_eid = 18'($urandom); f_dlc = 4'($urandom);
      for (int i = 0; i < 8; i++) f_data[i] = 8'($urandom);
      if ($urandom_range(9, 0) == 0) f_crcx = 15'(1 << $urandom_range(14, 0));
      if ($urandom_range(9, 0) == 0) f_bad = int'($urandom_range(3, 1));
      run_frame(int'($urandom_range(2, 0)));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R12 watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule